// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block turns the peripheral clock into the SCL waveform of an I2C master. A 32-bit divider word sets the lengths of the low phase and the high phase separately. Each count step of either field is worth eight peripheral clocks, and a field value of zero still gives one step. While SCL is low, a one-cycle drive strobe tells the byte engine when to change SDA. While SCL is high, a one-cycle sample strobe tells it when to read SDA. The sample strobe also serves as the START and STOP hook: an SDA edge placed there has half of the high phase as setup time and the other half as hold time.

The block is a three-state machine with the states IDLE, LOW and HIGH. It moves IDLE→LOW when enable is seen high (begin). It moves LOW→HIGH at the end of the low count (rise) and HIGH→LOW at the end of the high count (fall, the period boundary). From LOW or HIGH it returns to IDLE when enable is low (halt). The divider word is taken only on the begin and fall transitions, so a phase that has started is never shortened. In IDLE, SCL is released high and the phase counter stays at zero.

Top module: `scl_timing_gen`

## Requirements
- R1: The low-phase count L is taken from div_word bits 15:0 and the high-phase count H from bits 31:16.
- R2: The low phase holds scl_o at 0 for exactly 8·(L+1) clock cycles.
- R3: The high phase holds scl_o at 1 for exactly 8·(H+1) cycles, so a full period lasts 8·((L+1)+(H+1)) cycles.
- R4: drive_stb is high for exactly one cycle per low phase. It fires on low-phase cycle 4·(L+1), where the first low cycle is cycle 0.
- R5: sample_stb is high for exactly one cycle per high phase. It fires on high-phase cycle 4·(H+1), where the first high cycle is cycle 0.
- R6: period_stb is high only on the last cycle of each high phase.
- R7: The divider word is taken only on the begin transition and at each period boundary. A change made during a period first applies to the next low phase.
- R8: The cycle after enable is seen low, scl_o is 1 and no strobe fires until enable returns. A restart begins with a full low phase.
- R9: During reset, scl_o is 1 and all strobes are 0.
- R10: With both fields at zero, the period is the shortest possible: 16 cycles, split 8 low and 8 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low releases SCL |
| div_word | input | 32 | Divider word: high count in bits 31:16, low count in bits 15:0 |
| scl_o | output | 1 | SCL level (1 = released high) |
| drive_stb | output | 1 | One-cycle strobe in the middle of the low phase |
| sample_stb | output | 1 | One-cycle strobe in the middle of the high phase |
| period_stb | output | 1 | One-cycle strobe on the last cycle of each period |

## Verification
The hardest case to reach from the ports is a divider change that lands partway through a running period. Only the period boundary is allowed to take the new value. The stimulus waits until SCL has gone low, then writes a new word. It then measures the rest of that period and the whole next one, so that both the old and the new lengths are observed. Disabling in the middle of a phase is reached in a similar way, by dropping enable a few cycles into a low phase and then timing the low phase after the restart.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_t;
endpackage

// File: rtl/scl_phase_ctr.sv
// Position counter inside one SCL phase; a phase spans 8*(count+1) clocks.
module scl_phase_ctr #(
    parameter int DIV_W = 16,
    localparam int CW = DIV_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] count,
    output logic             at_mid,
    output logic             at_end
);
    logic [CW-1:0]    pos_q;
    logic [DIV_W:0]   steps;
    logic [CW-1:0]    last_pos;
    logic [CW-1:0]    mid_pos;

    always_comb begin
        steps    = {1'b0, count} + 1'b1;
        last_pos = {count, 3'b111};
        mid_pos  = {steps, 2'b00};
        at_end   = !hold && (pos_q == last_pos);
        at_mid   = !hold && (pos_q == mid_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else if (hold || at_end)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (pos_q <= last_pos)); // R2
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pos_q == '0)); // R8
endmodule

// File: rtl/scl_phase_fsm.sv
// IDLE/LOW/HIGH sequencer; latches the divider at begin and at period boundaries.
module scl_phase_fsm
    import scl_tg_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int WORD_W = 2 * DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WORD_W-1:0] div_word,
    input  logic              at_mid,
    input  logic              at_end,
    output logic              hold,
    output logic [DIV_W-1:0]  count,
    output logic              scl_o,
    output logic              drive_stb,
    output logic              sample_stb,
    output logic              period_stb
);
    scl_state_t       state_q, state_d;
    logic [DIV_W-1:0] lo_q, hi_q;
    logic             take_div;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = ST_LOW;
            ST_LOW:  if (!enable) state_d = ST_IDLE;
                     else if (at_end) state_d = ST_HIGH;
            ST_HIGH: if (!enable) state_d = ST_IDLE;
                     else if (at_end) state_d = ST_LOW;
            default: state_d = ST_IDLE;
        endcase
        take_div = enable && ((state_q == ST_IDLE) ||
                              (state_q == ST_HIGH && at_end));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_div) begin
                lo_q <= div_word[DIV_W-1:0];
                hi_q <= div_word[WORD_W-1:DIV_W];
            end
        end
    end

    always_comb begin
        hold       = 1'b1;
        count      = lo_q;
        scl_o      = 1'b1;
        drive_stb  = 1'b0;
        sample_stb = 1'b0;
        period_stb = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOW: begin
                hold      = !enable;
                scl_o     = 1'b0;
                drive_stb = enable && at_mid;
            end
            ST_HIGH: begin
                hold       = !enable;
                count      = hi_q;
                sample_stb = enable && at_mid;
                period_stb = enable && at_end;
            end
            default: ;
        endcase
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !drive_stb && !sample_stb)); // R8
    AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !scl_o); // R4
    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_o); // R5
    AST_PERIOD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> !scl_o); // R6
    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |=> $stable(lo_q) && $stable(hi_q)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drive_stb, sample_stb}) <= 1); // R4
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int DIV_W = 16,
    localparam int WORD_W = 2 * DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WORD_W-1:0] div_word,
    output logic              scl_o,
    output logic              drive_stb,
    output logic              sample_stb,
    output logic              period_stb
);
    logic             hold;
    logic             at_mid;
    logic             at_end;
    logic [DIV_W-1:0] count;

    scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .div_word   (div_word),
        .at_mid     (at_mid),
        .at_end     (at_end),
        .hold       (hold),
        .count      (count),
        .scl_o      (scl_o),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb),
        .period_stb (period_stb)
    );

    scl_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .count  (count),
        .at_mid (at_mid),
        .at_end (at_end)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |-> (scl_o && !drive_stb && !sample_stb && !period_stb)); // R9
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_word = '0;
    logic        scl_o, drive_stb, sample_stb, period_stb;

    int n_checks = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    always #10 clk = ~clk;

    scl_timing_gen u_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_word(div_word),
        .scl_o(scl_o), .drive_stb(drive_stb), .sample_stb(sample_stb),
        .period_stb(period_stb)
    );

    // {high count, low count}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {16'd0,  16'd0}, {16'd0,  16'd1}, {16'd1,  16'd0},
        {16'd3,  16'd3}, {16'd5,  16'd2}, {16'd2,  16'd7},
        {16'd9,  16'd20}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl);
        int guard = 0;
        while (scl_o !== lvl && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) timed_out = 1'b1;
    endtask

    // count cycles at level lvl; mpos = index of the mid strobe, ppos = index of period_stb
    task automatic measure(input logic lvl, output int len, output int mpos,
                           output int ppos, output int nmid);
        len = 0; mpos = -1; ppos = -1; nmid = 0;
        while (scl_o === lvl && len < 20000) begin
            if ((lvl == 1'b0 && drive_stb) || (lvl == 1'b1 && sample_stb)) begin
                mpos = len;
                nmid++;
            end
            if (period_stb) ppos = len;
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, hi, len, mpos, ppos, nmid;
        // R9 reset state
        #5;
        check("R9 scl", int'(scl_o), 1);
        check("R9 strobes", int'({drive_stb, sample_stb, period_stb}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            lo = int'(VEC[v][15:0]);   // R1 field positions
            hi = int'(VEC[v][31:16]);
            enable = 1'b0;
            div_word = VEC[v];
            @(negedge clk);
            enable = 1'b1;
            wait_level(1'b0);
            measure(1'b0, len, mpos, ppos, nmid);
            check("R2 low length", len, 8 * (lo + 1));
            check("R4 drive position", mpos, 4 * (lo + 1));
            check("R4 drive count", nmid, 1);
            measure(1'b1, len, mpos, ppos, nmid);
            check("R3 high length", len, 8 * (hi + 1));
            check("R5 sample position", mpos, 4 * (hi + 1));
            check("R5 sample count", nmid, 1);
            check("R6 period strobe", ppos, len - 1);
            if (v == 0) check("R10 fastest period", 8 * (lo + 1) + len, 16);
        end

        // R7: change divider mid-period
        enable = 1'b0;
        div_word = {16'd3, 16'd2};
        @(negedge clk);
        enable = 1'b1;
        wait_level(1'b0);
        repeat (3) @(negedge clk);
        div_word = {16'd1, 16'd5};
        wait_level(1'b1);
        measure(1'b1, len, mpos, ppos, nmid);
        check("R7 old high kept", len, 32);
        measure(1'b0, len, mpos, ppos, nmid);
        check("R7 new low applied", len, 48);
        measure(1'b1, len, mpos, ppos, nmid);
        check("R7 new high applied", len, 16);

        // R8: disable mid low phase, then restart
        wait_level(1'b0);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R8 released", int'(scl_o), 1);
        nmid = 0;
        for (int i = 0; i < 40; i++) begin
            if (!scl_o || drive_stb || sample_stb || period_stb) nmid++;
            @(negedge clk);
        end
        check("R8 idle quiet", nmid, 0);
        enable = 1'b1;
        wait_level(1'b0);
        measure(1'b0, len, mpos, ppos, nmid);
        check("R8 full low after restart", len, 48);

        if (timed_out) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=progress");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule